// File: doc/BRIEF.md
# Universal Shift and Storage Register with Shared Data Bus

This block is an 8-bit register that can hold its contents, shift toward either end, or load a whole word in parallel. A two-bit mode select picks the operation, which takes effect on the rising clock edge. The mode select may change from cycle to cycle.

The parallel data path is a single shared bus. The register drives the bus only when both output-enable inputs are low and the mode is not a load. During a load the register releases the bus, so that an external source can place the word to be captured. The three-state bus is modelled here as a separate input, a separate output and a drive-enable flag.

The two end stages each have a dedicated output. These outputs let several registers be chained into a longer shift path: stage 7 of the lower register feeds the left-serial input of the upper one, and stage 0 of the upper register feeds the right-serial input of the lower one. An active-low clear empties the register.

Top module: `univ_shift_store`

## Requirements
- R1: When `clr_n` is low at a rising clock edge, all eight stages become 0.
- R2: With `clr_n` high and `sel` = 00 (hold), the stored word is unchanged by a clock edge.
- R3: With `sel` = 01 (shift right), each stage i takes the old value of stage i+1, and stage 7 takes `ser_r`.
- R4: With `sel` = 10 (shift left), each stage i takes the old value of stage i-1, and stage 0 takes `ser_l`.
- R5: With `sel` = 11 (load), the stored word becomes `bus_in`.
- R6: `bus_drive` is 1 exactly when `oe1_n` = 0, `oe2_n` = 0 and `sel` is not 11. It follows its inputs with no clock delay.
- R7: While `bus_drive` is 1, `bus_out` equals the stored word. While it is 0, `bus_out` is all zeros.
- R8: `end_lo` always equals stage 0 and `end_hi` always equals stage 7, whatever the output-enable inputs are.
- R9: The clear takes priority over every mode, including load.
- R10: Two instances chained end to end (lower `end_hi` to upper `ser_l`, upper `end_lo` to lower `ser_r`) shift as one 16-bit register in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| clr_n | input | 1 | Synchronous active-low clear |
| sel | input | 2 | Mode: 00 hold, 01 shift right, 10 shift left, 11 load |
| ser_r | input | 1 | Bit entering stage 7 on shift right |
| ser_l | input | 1 | Bit entering stage 0 on shift left |
| oe1_n | input | 1 | Output enable, active low |
| oe2_n | input | 1 | Output enable, active low |
| bus_in | input | 8 | Value sampled from the shared bus |
| bus_out | output | 8 | Value driven onto the shared bus |
| bus_drive | output | 1 | 1 while the register drives the bus |
| end_lo | output | 1 | Stage 0, for chaining |
| end_hi | output | 1 | Stage 7, for chaining |

## Verification
A mode or clear applied before a rising edge shows up on `end_lo`, `end_hi` and `bus_out` just after that edge, one register stage later. The checks therefore sample 1 ns after the edge, with the mode set back to hold so that the bus is driven. `bus_drive` has no clock delay, so it is checked in the same cycle its enables change. The chained 16-bit shifts are checked one edge per step on both halves.

// File: rtl/usr_pkg.sv
// Shared types for the universal shift/storage register.
// Assumes the two-bit mode code listed below.
package usr_pkg;
    typedef enum logic [1:0] {
        MODE_HOLD = 2'b00,
        MODE_SHR  = 2'b01,
        MODE_SHL  = 2'b10,
        MODE_LOAD = 2'b11
    } usr_mode_e;
endpackage

// File: rtl/usr_stage.sv
// One bit of the register. The mode picks between keeping the bit, taking
// the upper or lower neighbour, or taking the parallel input.
// Assumes the neighbour inputs are already resolved at the ends.
module usr_stage
    import usr_pkg::*;
(
    input  logic      clk,
    input  logic      clr_n,
    input  usr_mode_e mode,
    input  logic      from_upper,
    input  logic      from_lower,
    input  logic      par_in,
    output logic      bit_q
);
    // Store one bit; the clear overrides every mode.
    always_ff @(posedge clk) begin
        if (!clr_n) begin
            bit_q <= 1'b0;
        end else begin
            case (mode)
                MODE_HOLD: bit_q <= bit_q;
                MODE_SHR:  bit_q <= from_upper;
                MODE_SHL:  bit_q <= from_lower;
                default:   bit_q <= par_in;
            endcase
        end
    end
endmodule

// File: rtl/usr_bus_port.sv
// Output side of the shared bus. Drives the stored word only when both
// enables are low and no load is in progress; otherwise it releases the bus.
// Assumes the bus is modelled as a separate output plus a drive flag.
module usr_bus_port
    import usr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             oe1_n,
    input  logic             oe2_n,
    input  usr_mode_e        mode,
    input  logic [WIDTH-1:0] word,
    output logic [WIDTH-1:0] bus_out,
    output logic             bus_drive
);
    // Decide ownership of the bus and gate the driven value.
    always_comb begin
        bus_drive = !oe1_n && !oe2_n && (mode != MODE_LOAD);
        bus_out   = bus_drive ? word : '0;
    end
endmodule

// File: rtl/univ_shift_store.sv
// Universal shift/storage register: hold, shift right, shift left and
// parallel load over a shared bus, with end-stage outputs for chaining.
// Assumes a synchronous active-low clear and a single clock.
module univ_shift_store
    import usr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [1:0]       sel,
    input  logic             ser_r,
    input  logic             ser_l,
    input  logic             oe1_n,
    input  logic             oe2_n,
    input  logic [WIDTH-1:0] bus_in,
    output logic [WIDTH-1:0] bus_out,
    output logic             bus_drive,
    output logic             end_lo,
    output logic             end_hi
);
    localparam int TOP = WIDTH - 1;

    usr_mode_e        mode;
    logic [WIDTH-1:0] store_q;

    assign mode = usr_mode_e'(sel);

    // Build one stage per bit; the end stages take the serial inputs.
    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        logic up_bit;
        logic lo_bit;
        if (i == TOP) begin : g_top
            assign up_bit = ser_r;
        end else begin : g_mid_up
            assign up_bit = store_q[i+1];
        end
        if (i == 0) begin : g_bot
            assign lo_bit = ser_l;
        end else begin : g_mid_lo
            assign lo_bit = store_q[i-1];
        end
        usr_stage u_stage (
            .clk       (clk),
            .clr_n     (clr_n),
            .mode      (mode),
            .from_upper(up_bit),
            .from_lower(lo_bit),
            .par_in    (bus_in[i]),
            .bit_q     (store_q[i])
        );
    end

    usr_bus_port #(.WIDTH(WIDTH)) u_bus (
        .oe1_n    (oe1_n),
        .oe2_n    (oe2_n),
        .mode     (mode),
        .word     (store_q),
        .bus_out  (bus_out),
        .bus_drive(bus_drive)
    );

    // Bring out the end stages for chaining.
    assign end_lo = store_q[0];
    assign end_hi = store_q[TOP];
endmodule

// File: rtl/univ_shift_store_chk.sv
// Property checker for univ_shift_store, attached with bind.
// Assumes it can see the internal stored word store_q.
module univ_shift_store_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             clr_n,
    input logic [1:0]       sel,
    input logic             ser_r,
    input logic             ser_l,
    input logic             oe1_n,
    input logic             oe2_n,
    input logic [WIDTH-1:0] bus_in,
    input logic [WIDTH-1:0] bus_out,
    input logic             bus_drive,
    input logic             end_lo,
    input logic             end_hi,
    input logic [WIDTH-1:0] store_q
);
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) !clr_n |=> store_q == '0); // R1
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!clr_n)
        sel == 2'b00 |=> $stable(store_q)); // R2
    AST_SHIFT_RIGHT: assert property (@(posedge clk) disable iff (!clr_n)
        sel == 2'b01 |=> store_q == {$past(ser_r), $past(store_q[WIDTH-1:1])}); // R3
    AST_SHIFT_LEFT: assert property (@(posedge clk) disable iff (!clr_n)
        sel == 2'b10 |=> store_q == {$past(store_q[WIDTH-2:0]), $past(ser_l)}); // R4
    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!clr_n)
        sel == 2'b11 |=> store_q == $past(bus_in)); // R5
    AST_LOAD_RELEASES: assert property (@(posedge clk) disable iff (!clr_n)
        sel == 2'b11 |-> !bus_drive); // R6
    AST_DISABLED_RELEASES: assert property (@(posedge clk) disable iff (!clr_n)
        (oe1_n || oe2_n) |-> !bus_drive); // R6
    AST_BUS_VALUE: assert property (@(posedge clk) disable iff (!clr_n)
        bus_drive |-> bus_out == store_q); // R7
    AST_END_STAGES: assert property (@(posedge clk) disable iff (!clr_n)
        end_lo == store_q[0] && end_hi == store_q[WIDTH-1]); // R8
endmodule

bind univ_shift_store univ_shift_store_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/test_univ_shift_store.sv
module test_univ_shift_store;
    logic       clk = 1'b0;
    logic       clr_n = 1'b0;
    logic [1:0] sel = 2'b00;
    logic       ser_r = 1'b0, ser_l = 1'b0;
    logic       oe1_n = 1'b0, oe2_n = 1'b0;
    logic [7:0] bus_in = 8'h00;
    logic [7:0] bus_out;
    logic       bus_drive, end_lo, end_hi;

    // chained pair
    logic [1:0] c_sel = 2'b00;
    logic       c_in_l = 1'b0, c_in_r = 1'b0;
    logic [7:0] lo_bus_in = 8'h00, hi_bus_in = 8'h00;
    logic [7:0] lo_bus_out, hi_bus_out;
    logic       lo_drive, hi_drive, lo_end_lo, lo_end_hi, hi_end_lo, hi_end_hi;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    univ_shift_store i_univ_shift_store (
        .clk(clk), .clr_n(clr_n), .sel(sel), .ser_r(ser_r), .ser_l(ser_l),
        .oe1_n(oe1_n), .oe2_n(oe2_n), .bus_in(bus_in), .bus_out(bus_out),
        .bus_drive(bus_drive), .end_lo(end_lo), .end_hi(end_hi));

    univ_shift_store i_casc_lo (
        .clk(clk), .clr_n(clr_n), .sel(c_sel), .ser_r(hi_end_lo), .ser_l(c_in_l),
        .oe1_n(1'b0), .oe2_n(1'b0), .bus_in(lo_bus_in), .bus_out(lo_bus_out),
        .bus_drive(lo_drive), .end_lo(lo_end_lo), .end_hi(lo_end_hi));

    univ_shift_store i_casc_hi (
        .clk(clk), .clr_n(clr_n), .sel(c_sel), .ser_r(c_in_r), .ser_l(lo_end_hi),
        .oe1_n(1'b0), .oe2_n(1'b0), .bus_in(hi_bus_in), .bus_out(hi_bus_out),
        .bus_drive(hi_drive), .end_lo(hi_end_lo), .end_hi(hi_end_hi));

    // vector: sel[19:18] ser_r[17] ser_l[16] bus_in[15:8] expected[7:0]
    localparam logic [19:0] VEC [10] = '{
        {2'b11, 1'b0, 1'b0, 8'hA5, 8'hA5},   // R5 load
        {2'b00, 1'b1, 1'b1, 8'h00, 8'hA5},   // R2 hold
        {2'b01, 1'b1, 1'b0, 8'h00, 8'hD2},   // R3 shift right, 1 in
        {2'b01, 1'b0, 1'b1, 8'hFF, 8'h69},   // R3 shift right, 0 in
        {2'b10, 1'b0, 1'b1, 8'h00, 8'hD3},   // R4 shift left, 1 in
        {2'b10, 1'b1, 1'b0, 8'hFF, 8'hA6},   // R4 shift left, 0 in
        {2'b11, 1'b1, 1'b1, 8'h3C, 8'h3C},   // R5 load
        {2'b00, 1'b0, 1'b0, 8'hFF, 8'h3C},   // R2 hold
        {2'b01, 1'b0, 1'b0, 8'h00, 8'h1E},   // R3
        {2'b10, 1'b0, 1'b1, 8'h00, 8'h3D}    // R4
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one edge, then return the mode to hold so the bus is observable
    task automatic step_main(input logic [1:0] s, input logic sr, input logic sl,
                             input logic [7:0] b);
        @(negedge clk);
        sel = s; ser_r = sr; ser_l = sl; bus_in = b;
        @(posedge clk);
        #1 sel = 2'b00;
        #0.5;
    endtask

    task automatic step_casc(input logic [1:0] s);
        @(negedge clk);
        c_sel = s;
        @(posedge clk);
        #1 c_sel = 2'b00;
        #0.5;
    endtask

    initial begin
        repeat (2) @(posedge clk);
        #1;
        check("R1 reset state", {8'h00, bus_out}, 16'h0000);
        check("R8 reset end stages", {14'h0, end_hi, end_lo}, 16'h0000);
        @(negedge clk) clr_n = 1'b1;

        foreach (VEC[k]) begin
            step_main(VEC[k][19:18], VEC[k][17], VEC[k][16], VEC[k][15:8]);
            check("R2/R3/R4/R5 vector bus_out", {8'h00, bus_out}, {8'h00, VEC[k][7:0]});
            check("R8 vector end stages", {14'h0, end_hi, end_lo},
                  {14'h0, VEC[k][7], VEC[k][0]});
        end

        // R6/R7: enables and load release the bus; R8 stays visible
        @(negedge clk) oe1_n = 1'b1;
        #0.5 check("R6 oe1_n high drive", {15'h0, bus_drive}, 16'h0);
        check("R7 released bus_out", {8'h00, bus_out}, 16'h0000);
        check("R8 ends with bus off", {14'h0, end_hi, end_lo}, 16'h0001);
        oe1_n = 1'b0; oe2_n = 1'b1;
        #0.5 check("R6 oe2_n high drive", {15'h0, bus_drive}, 16'h0);
        oe2_n = 1'b0;
        #0.5 check("R6 both low drive", {15'h0, bus_drive}, 16'h1);
        sel = 2'b11;
        #0.5 check("R6 load releases", {15'h0, bus_drive}, 16'h0);
        check("R7 load bus_out", {8'h00, bus_out}, 16'h0000);
        sel = 2'b00;

        // R9: clear beats load
        @(negedge clk) clr_n = 1'b0; sel = 2'b11; bus_in = 8'hFF;
        @(posedge clk) #1 sel = 2'b00;
        #0.5 check("R9 clear over load", {8'h00, bus_out}, 16'h0000);
        check("R1 clear end stages", {14'h0, end_hi, end_lo}, 16'h0000);
        @(negedge clk) clr_n = 1'b1;

        // R10: chained 16-bit shifting
        lo_bus_in = 8'h34; hi_bus_in = 8'h12;
        step_casc(2'b11);
        check("R10 chain load", {hi_bus_out, lo_bus_out}, 16'h1234);
        c_in_l = 1'b0;
        for (int n = 0; n < 4; n++) step_casc(2'b10);
        check("R10 chain shift left x4", {hi_bus_out, lo_bus_out}, 16'h2340);
        c_in_r = 1'b1;
        for (int n = 0; n < 4; n++) step_casc(2'b01);
        check("R10 chain shift right x4", {hi_bus_out, lo_bus_out}, 16'hF234);
        c_in_l = 1'b1;
        step_casc(2'b10);
        check("R10 chain shift left carry", {hi_bus_out, lo_bus_out}, 16'hE469);

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        #50000;
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule